// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by reading a two-level translation tree held in ordinary memory. A requester presents a 32-bit virtual address. The upper 20 bits form the virtual page number and the low 12 bits are the page offset. The walker captures the tree's base address from its root input when it accepts the request. It then makes at most two dependent word reads through a single-outstanding memory port whose response may come back after any number of cycles. At the end it raises a one-cycle strobe. A successful strobe carries the physical address and the entry's dirty flag. A fault strobe says whether the miss happened at the directory level or at the leaf level.

The top part of the page number selects a directory word. A zero directory word means the whole 4 MB region is unmapped, so the walker reports a fault at once and makes no second read. A non-zero word gives the base of a leaf table; its low 12 bits are ignored. The low part of the page number selects a leaf entry inside that table. Only one walk runs at a time, and new requests are not accepted until the walker is idle again. Caching of translations and the handling of faults are left to the surrounding logic.

Top module: `pt_walker`

## Requirements
- R1: After reset, busy, done, fault and mem_req_valid are all low.
- R2: The first memory read of a walk uses address root + 4 * vaddr[31:22], where root is the value of root_base in the cycle the request is accepted.
- R3: The second read uses address {dir[31:12], 12'h000} + 4 * vaddr[21:12], where dir is the directory word returned by the first read.
- R4: A directory word equal to zero ends the walk with fault high and fault_dir high, after exactly one memory read.
- R5: A leaf entry whose bit 0 (valid) is clear ends the walk with fault high and fault_dir low.
- R6: A leaf entry whose bit 0 is set ends the walk with done high. In that cycle paddr equals {leaf[31:12], vaddr[11:0]} and pte_dirty equals leaf bit 1.
- R7: busy is high from the cycle after a request is accepted up to, but not including, the strobe cycle. The done or fault strobe lasts exactly one cycle, and busy is low during it.
- R8: A request presented while a walk is in progress, or in its strobe cycle, is ignored and does not change that walk's addresses or result.
- R9: The walker waits any number of cycles for mem_rsp_valid. A mem_rsp_valid while no read is outstanding has no effect.
- R10: Each memory read is a single-cycle pulse on mem_req_valid, and a second read is never issued before the first one's response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request; taken only when idle |
| req_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Byte address of the directory table |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle strobe: translation succeeded |
| fault | output | 1 | One-cycle strobe: translation failed |
| fault_dir | output | 1 | With fault: the miss was a null directory word |
| paddr | output | 32 | Physical address, valid with done |
| pte_dirty | output | 1 | Dirty flag of the leaf entry, valid with done |
| mem_req_valid | output | 1 | Word read request pulse |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |

## Verification
The hardest case to reach is a second request or a stray memory response arriving while a walk is already in flight, because correct behaviour leaves no trace at the ports. The bench raises req_valid with a different address during the response waits of about a third of the walks. It also pulses mem_rsp_valid while the walker is idle. It then checks that the read addresses and the final result still match the first request. A sparse memory model supplies directory and leaf words computed from their indices, including null directory slots and invalid leaves. Its response latency is random, so every wait length from zero to five cycles occurs at both levels.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic [2:0] {
        PTW_IDLE,
        PTW_RD_DIR,
        PTW_WT_DIR,
        PTW_RD_LEAF,
        PTW_WT_LEAF,
        PTW_FIN
    } ptw_state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int AW     = 32,
    parameter int IW     = 10,
    parameter int ESHIFT = 2
) (
    input  logic [AW-1:0] base,
    input  logic [IW-1:0] idx,
    output logic [AW-1:0] addr
);
    localparam int PADW = AW - IW - ESHIFT;

    logic [AW-1:0] byte_off;

    always_comb begin
        byte_off = {{PADW{1'b0}}, idx, {ESHIFT{1'b0}}};
        addr     = base + byte_off;
    end
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
    parameter int DW   = 32,
    parameter int PG_W = 12
) (
    input  logic [DW-1:0]      entry,
    output logic               is_null,
    output logic               valid,
    output logic               dirty,
    output logic [DW-PG_W-1:0] frame,
    output logic [DW-1:0]      tbl_base
);
    always_comb begin
        is_null  = (entry == '0);
        valid    = entry[0];
        dirty    = entry[1];
        frame    = entry[DW-1:PG_W];
        tbl_base = {entry[DW-1:PG_W], {PG_W{1'b0}}};
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int PG_W   = 12,
    parameter int HI_W   = 10,
    parameter int LO_W   = 10,
    parameter int ESHIFT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [VA_W-1:0] root_base,
    output logic            busy,
    output logic            done,
    output logic            fault,
    output logic            fault_dir,
    output logic [VA_W-1:0] paddr,
    output logic            pte_dirty,
    output logic            mem_req_valid,
    output logic [VA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [VA_W-1:0] mem_rsp_data
);
    localparam int VPN_W = HI_W + LO_W;
    localparam int PPN_W = VA_W - PG_W;

    typedef struct packed {
        ptw_state_e        st;
        logic [VPN_W-1:0]  vpn;
        logic [PG_W-1:0]   ofs;
        logic [VA_W-1:0]   root;
        logic [VA_W-1:0]   tbl;
        logic [PPN_W-1:0]  ppn;
        logic              dirty;
        logic              flt;
        logic              nul;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    logic [VA_W-1:0]  dir_addr, leaf_addr;
    logic             ent_null, ent_valid, ent_dirty;
    logic [PPN_W-1:0] ent_frame;
    logic [VA_W-1:0]  ent_tbl;

    ptw_addr_gen #(.AW(VA_W), .IW(HI_W), .ESHIFT(ESHIFT)) u_dir_addr (
        .base (r_q.root),
        .idx  (r_q.vpn[VPN_W-1 -: HI_W]),
        .addr (dir_addr)
    );

    ptw_addr_gen #(.AW(VA_W), .IW(LO_W), .ESHIFT(ESHIFT)) u_leaf_addr (
        .base (r_q.tbl),
        .idx  (r_q.vpn[LO_W-1:0]),
        .addr (leaf_addr)
    );

    ptw_entry_decode #(.DW(VA_W), .PG_W(PG_W)) u_decode (
        .entry    (mem_rsp_data),
        .is_null  (ent_null),
        .valid    (ent_valid),
        .dirty    (ent_dirty),
        .frame    (ent_frame),
        .tbl_base (ent_tbl)
    );

    always_comb begin
        r_d           = r_q;
        mem_req_valid = 1'b0;
        mem_req_addr  = '0;
        unique case (r_q.st)
            PTW_IDLE: begin
                if (req_valid) begin
                    r_d.vpn   = req_vaddr[VA_W-1:PG_W];
                    r_d.ofs   = req_vaddr[PG_W-1:0];
                    r_d.root  = root_base;
                    r_d.flt   = 1'b0;
                    r_d.nul   = 1'b0;
                    r_d.dirty = 1'b0;
                    r_d.ppn   = '0;
                    r_d.st    = PTW_RD_DIR;
                end
            end
            PTW_RD_DIR: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = dir_addr;
                r_d.st        = PTW_WT_DIR;
            end
            PTW_WT_DIR: begin
                if (mem_rsp_valid) begin
                    if (ent_null) begin
                        r_d.flt = 1'b1;
                        r_d.nul = 1'b1;
                        r_d.st  = PTW_FIN;
                    end else begin
                        r_d.tbl = ent_tbl;
                        r_d.st  = PTW_RD_LEAF;
                    end
                end
            end
            PTW_RD_LEAF: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = leaf_addr;
                r_d.st        = PTW_WT_LEAF;
            end
            PTW_WT_LEAF: begin
                if (mem_rsp_valid) begin
                    if (ent_valid) begin
                        r_d.ppn   = ent_frame;
                        r_d.dirty = ent_dirty;
                    end else begin
                        r_d.flt = 1'b1;
                    end
                    r_d.st = PTW_FIN;
                end
            end
            PTW_FIN: begin
                r_d.st = PTW_IDLE;
            end
            default: r_d.st = PTW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: PTW_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        busy      = (r_q.st != PTW_IDLE) && (r_q.st != PTW_FIN);
        done      = (r_q.st == PTW_FIN) && !r_q.flt;
        fault     = (r_q.st == PTW_FIN) && r_q.flt;
        fault_dir = r_q.nul;
        paddr     = {r_q.ppn, r_q.ofs};
        pte_dirty = r_q.dirty;
    end

    // Checker state: reads issued in the current walk, and the offset as requested.
    logic [1:0]      chk_reads;
    logic [PG_W-1:0] chk_ofs;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_reads <= '0;
            chk_ofs   <= '0;
        end else if (r_q.st == PTW_IDLE && req_valid) begin
            chk_reads <= '0;
            chk_ofs   <= req_vaddr[PG_W-1:0];
        end else if (mem_req_valid && chk_reads != 2'd3) begin
            chk_reads <= chk_reads + 2'd1;
        end
    end

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == PTW_IDLE && req_valid) |=> busy);

    assert_strobe_short_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |-> (!busy && !(done && fault)) ##1 !(done || fault));

    assert_null_one_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && fault_dir) |-> chk_reads == 2'd1);

    assert_full_two_reads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> chk_reads == 2'd2);

    assert_offset_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> paddr[PG_W-1:0] == chk_ofs);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_valid && !done && !fault) |=> !busy && !mem_req_valid);
endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
    localparam logic [31:0] ROOT  = 32'h0010_0000;
    localparam logic [31:0] LBASE = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] root_base = ROOT;
    logic        busy, done, fault, fault_dir, pte_dirty;
    logic [31:0] paddr;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    pt_walker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .root_base(root_base), .busy(busy), .done(done), .fault(fault),
        .fault_dir(fault_dir), .paddr(paddr), .pte_dirty(pte_dirty),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 180000) begin
            fails = fails + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<180000", cycles);
            finish_run();
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] dir_word(input int i);
        if (i % 5 == 2) return 32'h0;
        return LBASE + (32'(i) << 12) + ((32'(i) * 32'd13) & 32'hFFF);
    endfunction

    function automatic logic [31:0] leaf_word(input int i, input int j);
        logic [19:0] ppn;
        logic        v, d;
        ppn = 20'((i * 37 + j * 11 + 5) & 32'hFFFFF);
        v   = ((i + j) % 4) != 3;
        d   = (j % 3) == 0;
        return {ppn, 10'h0, d, v};
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        if (a >= ROOT && a < ROOT + 32'h1000) return dir_word(int'((a - ROOT) >> 2));
        if (a >= LBASE && a < LBASE + 32'h0040_0000)
            return leaf_word(int'((a - LBASE) >> 12), int'((a >> 2) & 32'h3FF));
        return 32'hDEAD_BEEF;
    endfunction

    function automatic int pick(input int k);
        if (k < 24) return k;
        case (k)
            24: return 511;
            25: return 512;
            26: return 1022;
            default: return 1023;
        endcase
    endfunction

    task automatic walk(input int i, input int j, input logic [11:0] ofs, input bit inject);
        logic [31:0] va, dw, lw, a1, a2;
        int nreq, guard, lat;
        bit fin, busy_bad;
        va = {i[9:0], j[9:0], ofs};
        dw = dir_word(i);
        lw = leaf_word(i, j);
        a1 = ROOT + 32'(i) * 4;
        a2 = {dw[31:12], 12'h0} + 32'(j) * 4;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0; req_vaddr = ~va;
        nreq = 0; guard = 0; fin = 0; busy_bad = 0;
        while (!fin && guard < 300) begin
            guard++;
            if (done || fault) begin
                fin = 1;
            end else begin
                if (!busy) busy_bad = 1;
                if (mem_req_valid) begin
                    nreq++;
                    if (nreq == 1) chk(mem_req_addr == a1, "R2 dir read addr", mem_req_addr, a1);
                    else if (nreq == 2) chk(mem_req_addr == a2, "R3 leaf read addr", mem_req_addr, a2);
                    lat = int'($urandom % 6);
                    if (inject) begin req_valid = 1'b1; req_vaddr = va ^ 32'h0123_4000; end
                    for (int w = 0; w <= lat; w++) begin
                        @(negedge clk);
                        req_valid = 1'b0;
                        if (mem_req_valid) busy_bad = 1;
                    end
                    mem_rsp_valid = 1'b1; mem_rsp_data = mem_word(mem_req_addr_q(nreq, a1, a2));
                    @(negedge clk);
                    mem_rsp_valid = 1'b0; mem_rsp_data = $urandom;
                end else begin
                    @(negedge clk);
                end
            end
        end
        chk(fin, "R9 walk completes", 32'(guard), 32'd300);
        chk(!busy_bad, "R7 R10 busy held, no early read", 32'(busy_bad), 32'd0);
        chk(!busy, "R7 busy low at strobe", 32'(busy), 32'd0);
        if (dw == 0) begin
            chk(fault && fault_dir && !done, "R4 null directory fault", {29'd0, done, fault, fault_dir}, 32'h3);
            chk(nreq == 1, "R4 single read", 32'(nreq), 32'd1);
        end else begin
            chk(nreq == 2, "R3 two reads", 32'(nreq), 32'd2);
            if (!lw[0]) begin
                chk(fault && !fault_dir && !done, "R5 invalid leaf fault", {29'd0, done, fault, fault_dir}, 32'h2);
            end else begin
                chk(done && !fault, "R6 done strobe", {30'd0, done, fault}, 32'h2);
                chk(paddr == {lw[31:12], ofs}, "R6 paddr R8", paddr, {lw[31:12], ofs});
                chk(pte_dirty == lw[1], "R6 dirty", 32'(pte_dirty), 32'(lw[1]));
            end
        end
        @(negedge clk);
        chk(!done && !fault, "R7 strobe one cycle", {30'd0, done, fault}, 32'h0);
    endtask

    // The address being answered is the one the bench recorded for this read.
    function automatic logic [31:0] mem_req_addr_q(input int n, input logic [31:0] a1, input logic [31:0] a2);
        return (n == 1) ? a1 : a2;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fault && !mem_req_valid, "R1 reset outputs",
            {28'd0, busy, done, fault, mem_req_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: stray responses while idle
        mem_rsp_valid = 1'b1; mem_rsp_data = 32'h0;
        repeat (2) @(negedge clk);
        mem_rsp_valid = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !fault && !mem_req_valid, "R9 idle ignores response",
            {28'd0, busy, done, fault, mem_req_valid}, 32'h0);
        for (int ki = 0; ki < 28; ki++) begin
            for (int kj = 0; kj < 28; kj++) begin
                int i, j;
                logic [11:0] ofs;
                i = pick(ki);
                j = pick(kj);
                ofs = (j == 1023) ? 12'hFFF : 12'((i * j * 7 + i) & 32'hFFF);
                walk(i, j, ofs, ((i + j) % 3) == 0);
            end
        end
        finish_run();
    end
endmodule